// File: doc/BRIEF.md
# Receive Packet Page Writer

This block takes one received packet as a byte stream (source identifier, destination identifier, then the message bytes) and writes it into one 512-byte page of a byte-wide buffer RAM. The stored page uses a length-coded header: offset 0 holds the source identifier and offset 1 the destination identifier. The next one or two bytes hold a count value, and the message is placed so that its final byte lands at the end of the region. A host can read the message where it lies, or send it out again after changing only the two identifier bytes.

The message length is only known at the end marker, so the block first gathers the message in an internal staging store. It then checks the length and writes the page in one burst of consecutive cycles. A packet whose length cannot be coded is dropped without touching the page. Software arms a reception with a page number and a long-packet enable. When the page is complete, a done flag rises and stays high until the next arm.

Top module: `rx_page_writer`

## Requirements
- R1: After reset, `ram_we` and `rx_done` are 0 and no write occurs until a reception is armed and a packet arrives.
- R2: A pulse on `rx_arm` while no page write is in progress clears `rx_done` and latches `page_sel` and `long_en`. Every later write of that reception uses `ram_addr = {latched page, 9-bit offset}`, whatever `page_sel` does afterwards.
- R3: The first stream byte (marked by `in_first`) is written at offset 0 and the second at offset 1.
- R4: A short packet has N message bytes with 1 <= N <= 253. Offset 2 receives 256-N and message byte i goes to offset 256-N+i, so the last byte is at offset 255.
- R5: A long packet has 257 <= N <= 508 and needs `long_en` set at arm time. Offset 2 receives 0, offset 3 receives 512-N, and message byte i goes to offset 512-N+i, so the last byte is at offset 511.
- R6: A packet with N in 257..508 that arrives while the latched long enable is 0 causes no write, and `rx_done` stays 0.
- R7: A packet with N = 0, N in 254..256, or N > 508 causes no write and leaves `rx_done` at 0. The block stays armed, and a following valid packet is stored normally.
- R8: A page write is one `ram_we` pulse per cycle for consecutive cycles, at strictly rising offsets starting at 0. `rx_done` rises in the cycle after the final write strobe.
- R9: While `rx_done` is 1, stream input is ignored: there are no writes and the flag stays 1 until the next arm.
- R10: Bytes with `in_valid` that arrive before an `in_first` byte are ignored. Cycles with `in_valid` low inside a packet are skipped without effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_arm | input | 1 | Arm a new reception (one-cycle pulse) |
| page_sel | input | PAGE_W | Page to receive into, sampled at arm |
| long_en | input | 1 | Allow long packets, sampled at arm |
| in_valid | input | 1 | Stream byte valid |
| in_first | input | 1 | Marks the first byte (source identifier) |
| in_last | input | 1 | Marks the final byte of the packet |
| in_data | input | 8 | Stream byte |
| ram_we | output | 1 | Buffer RAM write strobe |
| ram_addr | output | PAGE_W+9 | Buffer RAM byte address {page, offset} |
| ram_wdata | output | 8 | Buffer RAM write data |
| rx_done | output | 1 | Packet stored completely in the page |

## Verification
A wrong length decision shows up within a few cycles of the end marker: either a burst appears for a packet that should be dropped, or a count byte differs from 256-N or 512-N. A wrong staging index or payload pointer shows as a data mismatch at some offset of the burst. A wrong end condition moves the final offset away from 255 or 511 and shifts when `rx_done` rises. Sweeping every short length and a spread of long lengths across all pages exposes these faults at the RAM port, one burst after the packet ends.

// File: rtl/rx_page_writer.sv
module rx_page_writer #(
  parameter int PAGE_W    = 2,
  parameter int SHORT_MAX = 253,
  parameter int LONG_MIN  = 257,
  parameter int LONG_MAX  = 508
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_arm,
  input  logic [PAGE_W-1:0] page_sel,
  input  logic              long_en,
  input  logic              in_valid,
  input  logic              in_first,
  input  logic              in_last,
  input  logic [7:0]        in_data,
  output logic              ram_we,
  output logic [PAGE_W+8:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic              rx_done
);
  localparam int OFF_W = 9;
  localparam int DEPTH = 1 << OFF_W;
  localparam int CNT_W = OFF_W + 1;
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(DEPTH + 64);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_COLLECT, S_HDR, S_PAY, S_FIN} st_t;
  st_t st;

  logic [7:0]        stage [DEPTH];
  logic [PAGE_W-1:0] page_q;
  logic              long_q, is_long;
  logic [7:0]        sid, did;
  logic [CNT_W-1:0]  cnt, n_q;
  logic [OFF_W-1:0]  base, pidx;
  logic [1:0]        hstep;

  logic              take, busy;
  logic [CNT_W-1:0]  cnt_nx, n_nx;
  logic              fits_short, fits_long;
  logic [7:0]        hdr_byte;

  assign busy   = (st == S_HDR) || (st == S_PAY) || (st == S_FIN);
  assign take   = in_valid && ((st == S_COLLECT) || ((st == S_WAIT) && in_first));
  assign cnt_nx = in_first ? CNT_W'(1) : ((cnt >= CNT_SAT) ? cnt : cnt + 1'b1);
  assign n_nx   = cnt_nx - CNT_W'(2);
  assign fits_short = (cnt_nx >= CNT_W'(3)) && (n_nx <= CNT_W'(SHORT_MAX));
  assign fits_long  = long_q && (cnt_nx >= CNT_W'(3)) &&
                      (n_nx >= CNT_W'(LONG_MIN)) && (n_nx <= CNT_W'(LONG_MAX));

  always_comb begin
    case (hstep)
      2'd0:    hdr_byte = sid;
      2'd1:    hdr_byte = did;
      2'd2:    hdr_byte = is_long ? 8'd0 : base[7:0];
      default: hdr_byte = base[7:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (take && !in_first && cnt >= CNT_W'(2) && cnt < CNT_W'(LONG_MAX + 2))
      stage[OFF_W'(cnt - CNT_W'(2))] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      page_q    <= '0;
      long_q    <= 1'b0;
      is_long   <= 1'b0;
      sid       <= '0;
      did       <= '0;
      cnt       <= '0;
      n_q       <= '0;
      base      <= '0;
      pidx      <= '0;
      hstep     <= '0;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
      rx_done   <= 1'b0;
    end else begin
      ram_we <= 1'b0;
      if (rx_arm && !busy) begin
        page_q  <= page_sel;
        long_q  <= long_en;
        rx_done <= 1'b0;
        cnt     <= '0;
        st      <= S_WAIT;
      end else begin
        case (st)
          S_WAIT, S_COLLECT: begin
            if (take) begin
              cnt <= cnt_nx;
              if (in_first) sid <= in_data;
              else if (cnt == CNT_W'(1)) did <= in_data;
              if (in_last) begin
                n_q   <= n_nx;
                hstep <= 2'd0;
                if (fits_short) begin
                  is_long <= 1'b0;
                  base    <= OFF_W'(CNT_W'(256) - n_nx);
                  st      <= S_HDR;
                end else if (fits_long) begin
                  is_long <= 1'b1;
                  base    <= OFF_W'(CNT_W'(512) - n_nx);
                  st      <= S_HDR;
                end else begin
                  st <= S_WAIT;
                end
              end else begin
                st <= S_COLLECT;
              end
            end
          end
          S_HDR: begin
            ram_we    <= 1'b1;
            ram_addr  <= {page_q, 7'd0, hstep};
            ram_wdata <= hdr_byte;
            hstep     <= hstep + 1'b1;
            if (hstep == (is_long ? 2'd3 : 2'd2)) begin
              pidx <= '0;
              st   <= S_PAY;
            end
          end
          S_PAY: begin
            ram_we    <= 1'b1;
            ram_addr  <= {page_q, base + pidx};
            ram_wdata <= stage[pidx];
            pidx      <= pidx + 1'b1;
            if (CNT_W'(pidx) == n_q - CNT_W'(1)) st <= S_FIN;
          end
          S_FIN: begin
            rx_done <= 1'b1;
            st      <= S_IDLE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_page_writer_chk.sv
module rx_page_writer_chk #(
  parameter int PAGE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_arm,
  input logic              ram_we,
  input logic [PAGE_W+8:0] ram_addr,
  input logic              rx_done
);
  p_quiet_while_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> !ram_we);

  p_arm_clears_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_arm && rx_done) |=> !rx_done);

  p_done_follows_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) |-> $past(ram_we));

  p_rising_offsets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && $past(ram_we)) |-> (ram_addr[8:0] > $past(ram_addr[8:0])));

  p_burst_starts_at_sid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !$past(ram_we)) |-> (ram_addr[8:0] == 9'd0));

  p_last_at_region_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) |-> ($past(ram_addr[8:0]) == 9'd255 || $past(ram_addr[8:0]) == 9'd511));

  p_page_steady_in_burst_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && $past(ram_we)) |-> (ram_addr[PAGE_W+8:9] == $past(ram_addr[PAGE_W+8:9])));
endmodule

bind rx_page_writer rx_page_writer_chk #(.PAGE_W(PAGE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_arm(rx_arm), .ram_we(ram_we),
  .ram_addr(ram_addr), .rx_done(rx_done)
);

// File: tb/rx_page_writer_tb_top.sv
`timescale 1ns/1ps
module rx_page_writer_tb_top;
  localparam int PW = 2;

  logic clk = 0, rst_n = 0;
  logic rx_arm = 0, long_en = 0;
  logic [PW-1:0] page_sel = '0;
  logic in_valid = 0, in_first = 0, in_last = 0;
  logic [7:0] in_data = '0;
  logic ram_we, rx_done;
  logic [PW+8:0] ram_addr;
  logic [7:0] ram_wdata;

  always #2 clk = ~clk;

  rx_page_writer #(.PAGE_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_arm(rx_arm), .page_sel(page_sel),
    .long_en(long_en), .in_valid(in_valid), .in_first(in_first),
    .in_last(in_last), .in_data(in_data), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .rx_done(rx_done)
  );

  int checks = 0, fails = 0;
  int cyc = 0;
  int cur_n, cur_h, cur_base, cur_page;
  bit cur_long;
  int wr_cnt, bad, bad_k, last_we_cyc, done_cyc;
  logic [PW+8:0] bad_addr, bad_eaddr;
  logic [7:0] bad_data, bad_edata;
  logic done_prev = 0;

  function automatic logic [7:0] pay(int n, int i);
    return 8'((n * 7 + i * 13 + 5) & 255);
  endfunction

  function automatic int exp_off(int k);
    return (k < cur_h) ? k : cur_base + (k - cur_h);
  endfunction

  function automatic logic [7:0] exp_dat(int k);
    case (k)
      0: return 8'((cur_n ^ 8'hA5) & 255);
      1: return 8'((cur_n * 3 + 1) & 255);
      2: return cur_long ? 8'd0 : 8'(cur_base);
      3: return cur_long ? 8'(cur_base) : pay(cur_n, 0);
      default: return pay(cur_n, k - cur_h);
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && ram_we) begin
      logic [PW+8:0] ea;
      ea = {PW'(cur_page), 9'(exp_off(wr_cnt))};
      if (bad == 0 && (ram_addr != ea || ram_wdata != exp_dat(wr_cnt))) begin
        bad = 1; bad_k = wr_cnt;
        bad_addr = ram_addr; bad_eaddr = ea;
        bad_data = ram_wdata; bad_edata = exp_dat(wr_cnt);
      end
      wr_cnt++;
      last_we_cyc = cyc;
    end
    if (rx_done && !done_prev) done_cyc = cyc;
    done_prev = rx_done;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic arm(int page, bit lng);
    @(negedge clk);
    rx_arm = 1; page_sel = PW'(page); long_en = lng;
    @(negedge clk);
    rx_arm = 0; page_sel = ~PW'(page); long_en = ~lng;
  endtask

  task automatic send(int n);
    for (int i = 0; i < n + 2; i++) begin
      if (i % 11 == 4) begin
        in_valid = 0;
        @(negedge clk);
      end
      in_valid = 1; in_first = (i == 0); in_last = (i == n + 1);
      in_data = (i == 0) ? 8'((n ^ 8'hA5) & 255) :
                (i == 1) ? 8'((n * 3 + 1) & 255) : pay(n, i - 2);
      @(negedge clk);
    end
    in_valid = 0; in_first = 0; in_last = 0;
  endtask

  task automatic start_obs(int n, int page, bit lng);
    cur_n = n; cur_page = page;
    cur_long = (n >= 257);
    cur_h = cur_long ? 4 : 3;
    cur_base = cur_long ? 512 - n : 256 - n;
    wr_cnt = 0; bad = 0; done_cyc = -1;
  endtask

  task automatic run_pkt(int n, int page, bit lng, string req);
    bit ok;
    ok = (n >= 1 && n <= 253) || (lng && n >= 257 && n <= 508);
    arm(page, lng);
    start_obs(n, page, lng);
    send(n);
    if (ok) begin
      for (int t = 0; t < n + 30 && !rx_done; t++) @(negedge clk);
      @(negedge clk);
      check(rx_done == 1, req, "done after store", rx_done, 1);
      check(wr_cnt == cur_h + n, req, "write count", wr_cnt, cur_h + n);
      if (bad) begin
        check(0, req, $sformatf("write %0d addr", bad_k), bad_addr, bad_eaddr);
        check(0, req, $sformatf("write %0d data", bad_k), bad_data, bad_edata);
      end
      check(done_cyc - last_we_cyc == 1, "R8", "done lag", done_cyc - last_we_cyc, 1);
    end else begin
      repeat (20) @(negedge clk);
      check(rx_done == 0 && wr_cnt == 0, req, "dropped packet writes", wr_cnt, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(ram_we == 0 && rx_done == 0, "R1", "reset outputs", {ram_we, rx_done}, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    start_obs(10, 0, 0);
    send(10);
    repeat (20) @(negedge clk);
    check(wr_cnt == 0 && rx_done == 0, "R1", "unarmed writes", wr_cnt, 0);

    // R3 R4 R7 R2: every short length and the invalid ones around it, pages rotating
    for (int n = 0; n <= 262; n++)
      run_pkt(n, n % 4, (n % 3) == 0, (n == 0 || (n >= 254 && n <= 256)) ? "R7" : "R4");

    // R5 and R6: long lengths with and without the enable
    for (int n = 257; n <= 508; n += 9) run_pkt(n, (n / 9) % 4, 1, "R5");
    run_pkt(508, 3, 1, "R5");
    run_pkt(258, 1, 1, "R5");
    run_pkt(300, 2, 0, "R6");
    run_pkt(508, 0, 0, "R6");
    run_pkt(509, 1, 1, "R7");
    run_pkt(540, 2, 1, "R7");

    // R7: dropped packet followed by a valid one without re-arm
    arm(2, 0);
    start_obs(254, 2, 0);
    send(254);
    repeat (10) @(negedge clk);
    check(wr_cnt == 0, "R7", "oversize short writes", wr_cnt, 0);
    start_obs(40, 2, 0);
    send(40);
    repeat (60) @(negedge clk);
    check(rx_done == 1 && wr_cnt == 43 && bad == 0, "R7", "store after drop", wr_cnt, 43);

    // R9: stream ignored while done is high
    start_obs(20, 2, 0);
    send(20);
    repeat (40) @(negedge clk);
    check(wr_cnt == 0, "R9", "writes while done", wr_cnt, 0);
    check(rx_done == 1, "R9", "done held", rx_done, 1);

    // R10: stray bytes before a first marker
    arm(1, 0);
    start_obs(17, 1, 0);
    for (int i = 0; i < 6; i++) begin
      in_valid = 1; in_data = 8'hEE; in_last = (i == 5);
      @(negedge clk);
    end
    in_valid = 0; in_last = 0;
    send(17);
    repeat (40) @(negedge clk);
    check(rx_done == 1 && wr_cnt == 20 && bad == 0, "R10", "stray bytes ignored", wr_cnt, 20);

    // R2: arm clears done
    arm(3, 0);
    check(rx_done == 0, "R2", "arm clears done", rx_done, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule